// File: doc/BRIEF.md
# Servo Input Offset Averager and Compensator

This block learns the DC offset of four sampled servo input channels and then removes it. A latched command word arrives in parallel together with a one-cycle latch strobe. The command's upper byte is an address. When the address selects the measurement function, individual data bits choose which channels to measure. Each chosen channel then sums 256 consecutive samples, one per sample-enable strobe, and keeps the mean in its own average register.

After that, every channel's output is its live sample minus its stored average, clamped to the signed 8-bit range. The offsets are therefore cancelled continuously. Measurement has to be run before normal operation. While the last latched address is the measurement address, a shared status pin shows a busy flag. For any other address the pin carries a pass-through status input, so other status sources can share it.

Top module: `offset_avg_comp`

## Requirements
- R1: After reset every average register is zero, so each compensated output equals its live sample. The latched address is 0x00, so `status_out` follows `status_in`.
- R2: A latch strobe whose command bits [23:16] equal 0x38 and that sets at least one start bit begins a measurement. Busy is high from the first clock after the strobe, and `status_out` shows it.
- R3: A measurement consumes exactly 256 sample strobes. Busy stays high after 255 of them and goes low one clock after the 256th.
- R4: A measured channel's average is floor(sum of its 256 samples / 256), which is an arithmetic right shift by 8 of a 16-bit signed sum.
- R5: Start bits map to channels as follows: data bit 15 starts channel 0, bit 13 starts channel 1, bit 11 starts channel 2 and bit 4 starts channel 3. A channel that is not started keeps its previous average.
- R6: Several start bits in one command measure their channels in parallel over the same 256 strobes. Busy clears once, when all of them are done.
- R7: A measurement command latched while busy is ignored. The running measurement is not restarted or extended, and no extra channel is started. The address byte is still latched.
- R8: Compensated output of channel i = saturate(sample_i − average_i) to the range −128..127. Samples and outputs are packed with channel i in bits [8i+7:8i].
- R9: When the latched address is not 0x38, `status_out` equals `status_in`.
- R10: An address-0x38 command with no start bit set starts nothing. Busy stays low, `status_out` is 0, and `status_in` is ignored.
- R11: Sample strobes while no measurement runs leave all averages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 24 | Latched command: [23:16] address, [15:0] data |
| cmd_latch | input | 1 | One-cycle strobe marking a new command word |
| sample_en | input | 1 | Sample strobe, one per input sample |
| samples | input | 32 | Four signed 8-bit live samples, channel i in [8i+7:8i] |
| status_in | input | 1 | Status from another source, passed through for other addresses |
| status_out | output | 1 | Shared status pin: busy flag or pass-through |
| comp_out | output | 32 | Four signed 8-bit offset-compensated samples |

## Verification
The assertions check cycle-level invariants on every cycle. Busy only rises just after a latch strobe. The strobe counter stays within its window, and busy falls only on a final strobe. The channel selection cannot change during a measurement, and an average register changes only on its channel's final strobe. Only the bench scenarios can show the numerical results: floor rounding of negative means, the start-bit-to-channel mapping, saturation at both ends, the exact 256-strobe length when a second command arrives mid-run, and the status pin multiplexing across addresses.

// File: rtl/oac_pkg.sv
package oac_pkg;
   // width of a start-bit index inside the command data field
   localparam int IDX_W = 5;

   // signed difference of two samples, widened by one bit
   function automatic logic signed [8:0] widen_sub(input logic signed [7:0] a,
                                                  input logic signed [7:0] b);
      return {a[7], a} - {b[7], b};
   endfunction
endpackage

// File: rtl/oac_cmd_ctrl.sv
module oac_cmd_ctrl
   import oac_pkg::*;
#(
   parameter int                       CMD_W     = 24,
   parameter int                       ADDR_W    = 8,
   parameter int                       NUM_CH    = 4,
   parameter int                       CNT_W     = 8,
   parameter logic [ADDR_W-1:0]        MEAS_ADDR = 8'h38,
   parameter logic [NUM_CH*IDX_W-1:0]  START_MAP = {5'd4, 5'd11, 5'd13, 5'd15}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              cmd_latch,
   input  logic              sample_en,
   output logic [ADDR_W-1:0] addr_q,
   output logic              busy_q,
   output logic [NUM_CH-1:0] ch_clr,
   output logic [NUM_CH-1:0] ch_acc,
   output logic [NUM_CH-1:0] ch_fin
);
   localparam int DATA_W = CMD_W - ADDR_W;
   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

   if (DATA_W < 1) begin : g_bad_cmd
      $error("oac_cmd_ctrl: CMD_W must exceed ADDR_W");
   end

   logic [DATA_W-1:0] data_f;
   logic [NUM_CH-1:0] req;
   logic [NUM_CH-1:0] sel_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              addr_hit, go, last_strobe;

   assign data_f   = cmd_word[DATA_W-1:0];
   assign addr_hit = (cmd_word[CMD_W-1 -: ADDR_W] == MEAS_ADDR);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_req
      localparam int BIT = int'(START_MAP[i*IDX_W +: IDX_W]);
      if (BIT >= DATA_W) begin : g_bad_bit
         $error("oac_cmd_ctrl: start bit outside data field");
      end
      assign req[i] = data_f[BIT];
   end

   assign go          = cmd_latch & addr_hit & ~busy_q & (|req);
   assign last_strobe = busy_q & sample_en & (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         busy_q <= 1'b0;
         sel_q  <= '0;
         cnt_q  <= '0;
      end else begin
         if (cmd_latch) addr_q <= cmd_word[CMD_W-1 -: ADDR_W];
         if (go) begin
            sel_q  <= req;
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q && sample_en) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) busy_q <= 1'b0;
         end
      end
   end

   assign ch_clr = go ? req : '0;
   assign ch_acc = (busy_q & sample_en) ? sel_q : '0;
   assign ch_fin = last_strobe ? sel_q : '0;

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(cmd_latch));
   // R3
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(sample_en) && $past(cnt_q) == CNT_LAST);
   // R3
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> cnt_q == '0);
   // R7
   sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> $stable(sel_q));
   // R6
   fin_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_fin) |=> !busy_q);
endmodule

// File: rtl/oac_channel.sv
module oac_channel
   import oac_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int ACC_W    = 16,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       acc_en,
   input  logic                       fin,
   input  logic signed [SAMPLE_W-1:0] sample,
   output logic signed [SAMPLE_W-1:0] comp
);
   localparam int EXT_W = ACC_W - SAMPLE_W;

   if (ACC_W < SAMPLE_W + CNT_W) begin : g_bad_acc
      $error("oac_channel: accumulator too narrow for sample count");
   end
   if (SAMPLE_W != 8) begin : g_bad_sw
      $error("oac_channel: compensation path built for 8-bit samples");
   end

   logic signed [ACC_W-1:0]    acc_q, sum_nx, shifted;
   logic signed [SAMPLE_W-1:0] avg_q;
   logic signed [SAMPLE_W:0]   diff;

   assign sum_nx  = acc_q + {{EXT_W{sample[SAMPLE_W-1]}}, sample};
   assign shifted = sum_nx >>> CNT_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         avg_q <= '0;
      end else begin
         if (clr)
            acc_q <= '0;
         else if (acc_en)
            acc_q <= sum_nx;
         if (fin) avg_q <= shifted[SAMPLE_W-1:0];
      end
   end

   assign diff = widen_sub(sample, avg_q);

   if (SATURATE) begin : g_sat
      always_comb begin
         if (diff[SAMPLE_W] != diff[SAMPLE_W-1])
            comp = diff[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                  : {1'b0, {(SAMPLE_W-1){1'b1}}};
         else
            comp = diff[SAMPLE_W-1:0];
      end
   end else begin : g_wrap
      assign comp = diff[SAMPLE_W-1:0];
   end

   // R11
   avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(avg_q));
   // R4
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc_q == '0);
   // R8
   zero_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample == avg_q |-> comp == '0);
endmodule

// File: rtl/offset_avg_comp.sv
module offset_avg_comp
   import oac_pkg::*;
#(
   parameter int                       SAMPLE_W  = 8,
   parameter int                       NUM_CH    = 4,
   parameter int                       ACC_W     = 16,
   parameter int                       CNT_W     = 8,
   parameter int                       CMD_W     = 24,
   parameter int                       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]        MEAS_ADDR = 8'h38,
   parameter logic [NUM_CH*IDX_W-1:0]  START_MAP = {5'd4, 5'd11, 5'd13, 5'd15},
   parameter bit                       SATURATE  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CMD_W-1:0]             cmd_word,
   input  logic                         cmd_latch,
   input  logic                         sample_en,
   input  logic [NUM_CH*SAMPLE_W-1:0]   samples,
   input  logic                         status_in,
   output logic                         status_out,
   output logic [NUM_CH*SAMPLE_W-1:0]   comp_out
);
   logic [ADDR_W-1:0] addr_q;
   logic              busy;
   logic [NUM_CH-1:0] ch_clr, ch_acc, ch_fin;

   oac_cmd_ctrl #(
      .CMD_W(CMD_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CNT_W(CNT_W),
      .MEAS_ADDR(MEAS_ADDR), .START_MAP(START_MAP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_latch(cmd_latch),
      .sample_en(sample_en), .addr_q(addr_q), .busy_q(busy),
      .ch_clr(ch_clr), .ch_acc(ch_acc), .ch_fin(ch_fin)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      oac_channel #(
         .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .SATURATE(SATURATE)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .clr(ch_clr[i]), .acc_en(ch_acc[i]),
         .fin(ch_fin[i]), .sample(samples[i*SAMPLE_W +: SAMPLE_W]),
         .comp(comp_out[i*SAMPLE_W +: SAMPLE_W])
      );
   end

   assign status_out = (addr_q == MEAS_ADDR) ? busy : status_in;

   // R10
   idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && addr_q == MEAS_ADDR |-> !status_out);
endmodule

// File: tb/offset_avg_comp_test.sv
module offset_avg_comp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cmd_word = '0;
   logic        cmd_latch = 1'b0;
   logic        sample_en = 1'b0;
   logic [31:0] samples = '0;
   logic        status_in = 1'b0;
   logic        status_out;
   logic [31:0] comp_out;

   int checks = 0;
   int errors = 0;
   int ea [4] = '{0, 0, 0, 0};

   always #2.5 clk = ~clk;

   offset_avg_comp uut (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_latch(cmd_latch),
      .sample_en(sample_en), .samples(samples), .status_in(status_in),
      .status_out(status_out), .comp_out(comp_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sat8(input int v);
      return v > 127 ? 127 : (v < -128 ? -128 : v);
   endfunction

   task automatic check_comp(input logic [31:0] s, input string req);
      @(negedge clk);
      samples = s;
      #1;
      for (int c = 0; c < 4; c++) begin
         int sv, ex, ac;
         sv = int'($signed(s[c*8 +: 8]));
         ex = sat8(sv - ea[c]);
         ac = int'($signed(comp_out[c*8 +: 8]));
         check(ac == ex, req, ac, ex);
      end
   endtask

   task automatic latch(input logic [23:0] w);
      @(negedge clk);
      cmd_word = w; cmd_latch = 1'b1;
      @(negedge clk);
      cmd_latch = 1'b0;
   endtask

   task automatic strobes(input int n, input int k0, input logic [31:0] lo, input logic [31:0] hi);
      for (int k = k0; k < k0 + n; k++) begin
         @(negedge clk);
         samples = (k % 2 == 0) ? lo : hi;
         sample_en = 1'b1;
         @(negedge clk);
         sample_en = 1'b0;
      end
   endtask

   task automatic learn(input int c, input logic [31:0] lo, input logic [31:0] hi);
      ea[c] = (int'($signed(lo[c*8 +: 8])) + int'($signed(hi[c*8 +: 8]))) >>> 1;
   endtask

   task automatic t_reset;
      status_in = 1'b1;
      #1;
      check(status_out == 1'b1, "R1", status_out, 1);
      check_comp(32'h80_7F_05_FB, "R1");
   endtask

   task automatic t_passthru;
      latch({8'h12, 16'hFFFF});
      status_in = 1'b0; #1;
      check(status_out == 1'b0, "R9", status_out, 0);
      status_in = 1'b1; #1;
      check(status_out == 1'b1, "R9", status_out, 1);
   endtask

   task automatic t_single;
      logic [31:0] lo, hi;
      lo = 32'h00_00_0A_00; hi = 32'h00_00_0D_00;
      status_in = 1'b1;
      latch({8'h38, 16'h2000});
      #1;
      check(status_out == 1'b1, "R2", status_out, 1);
      strobes(255, 0, lo, hi);
      #1;
      check(status_out == 1'b1, "R3", status_out, 1);
      strobes(1, 255, lo, hi);
      #1;
      check(status_out == 1'b0, "R3", status_out, 0);
      learn(1, lo, hi);
      check_comp(32'h00_00_00_00, "R4");
   endtask

   task automatic t_parallel;
      logic [31:0] lo, hi;
      lo = 32'h80_11_64_FD; hi = 32'h80_22_64_FC;
      latch({8'h38, 16'h8010});
      strobes(255, 0, lo, hi);
      #1;
      check(status_out == 1'b1, "R6", status_out, 1);
      strobes(1, 255, lo, hi);
      #1;
      check(status_out == 1'b0, "R6", status_out, 0);
      learn(0, lo, hi);
      learn(3, lo, hi);
      check(ea[0] == -4 && ea[3] == -128, "R4", ea[0], -4);
      check_comp(32'h00_00_00_00, "R5");
   endtask

   task automatic t_saturate;
      check_comp(32'h7F_00_80_00, "R8");
      check_comp(32'h81_7F_7F_7F, "R8");
   endtask

   task automatic t_ignore;
      logic [31:0] lo, hi;
      lo = 32'h00_40_00_0A; hi = 32'h00_40_00_0C;
      latch({8'h38, 16'h8000});
      strobes(100, 0, lo, hi);
      latch({8'h38, 16'h0800});
      strobes(155, 100, lo, hi);
      #1;
      check(status_out == 1'b1, "R7", status_out, 1);
      strobes(1, 255, lo, hi);
      #1;
      check(status_out == 1'b0, "R7", status_out, 0);
      learn(0, lo, hi);
      check_comp(32'h00_00_00_00, "R7");
   endtask

   task automatic t_nostart;
      status_in = 1'b1;
      latch({8'h38, 16'h57EF});
      #1;
      check(status_out == 1'b0, "R10", status_out, 0);
      strobes(3, 0, 32'h11111111, 32'h22222222);
      #1;
      check(status_out == 1'b0, "R10", status_out, 0);
   endtask

   task automatic t_idle;
      strobes(300, 0, 32'h7F7F7F7F, 32'h80808080);
      check_comp(32'h10_F0_20_E0, "R11");
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_passthru();
      t_single();
      t_parallel();
      t_saturate();
      t_ignore();
      t_nostart();
      t_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule